// File: doc/BRIEF.md
# Digitizer Sample Trigger Controller

This block decides on which clock cycles a digitizer takes a sample. An 8-bit control word selects a trigger source and sets three mode bits: hold, infinite and one-shot. A second register holds the post-arm sample count. A third holds the divisor for a reference-period divider. All three are loaded over a plain write-enable port.

The source can be one of several asynchronous trigger lines, one of three synchronous bus strobes, or a divided copy of the reference line. Each asynchronous line is synchronized, and its rising edges are turned into single-cycle events.

An arm-start pulse loads the post-arm counter and makes the controller busy. While busy, each qualified trigger produces a one-cycle sample strobe. The controller drops back to idle when the count is used up or a one-shot sample is taken. Infinite mode keeps it busy until an abort arrives or until infinite mode is cleared. Clearing infinite mode always leaves room for at least one more sample.

Top module: `smp_trig_ctl`

## Requirements
- R1: While control bit 7 (hold) is 1, no trigger from any source produces a sample strobe, and the controller stays busy.
- R2: Control bits 4:2 pick the source. Lines are `trig_lines[0]` reference, `[1]` ECL line 0, `[2]` external 1, `[3]` ECL line 1, `[4]` external 2 and `[5]` TTL line. The codes are 000 reference, 001 ECL 0, 010 external 1, 100 divided reference, 101 ECL 1 and 110 external 2. Only the selected source yields samples.
- R3: With bits 4:2 = 011, bits 1:0 pick an internal source: 00 `bus_rd_stb`, 01 `get_stb`, 10 the TTL line `trig_lines[5]`, 11 `lbus_stb`.
- R4: Source code 111 never produces a sample strobe.
- R5: Each asynchronous line passes through a two-flop synchronizer. Each rising edge held for at least 3 cycles yields exactly one sample, and a level that stays high yields no more. Each single-cycle bus strobe yields one sample.
- R6: `arm_start` loads the post-arm count and sets `busy`. Each sample decrements the count, and `busy` falls after the count-th sample in normal mode. A loaded count of 0 acts as 1.
- R7: With bit 5 (one-shot) set and bit 6 clear, exactly one sample is taken and then `busy` falls, whatever the count.
- R8: With bit 6 (infinite) set, samples continue past the post-arm count and `busy` stays 1. Infinite mode overrides one-shot.
- R9: When bit 6 is cleared while busy, the remaining count is honoured. If the count was already used up, exactly one more sample is accepted before `busy` falls.
- R10: `abort` clears `busy` on the next cycle and suppresses any sample in that cycle. It wins over an `arm_start` in the same cycle.
- R11: With divisor n (n = 0 treated as 1), the divided-reference source gives one event per n reference rising edges. Writing the divisor restarts the division.
- R12: While idle, triggers produce no sample strobe.
- R13: After reset, `busy` and `sample_stb` are 0 and all registers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Load the control word |
| ctrl_wdata | input | 8 | Control word: hold, infinite, one-shot, source, internal source |
| cnt_we | input | 1 | Load the post-arm count register |
| cnt_wdata | input | CNT_W | Post-arm count value |
| div_we | input | 1 | Load the divisor and restart the divider |
| div_wdata | input | DIV_W | Reference divisor n |
| trig_lines | input | 6 | Asynchronous trigger lines (reference, ECL0, ext1, ECL1, ext2, TTL) |
| bus_rd_stb | input | 1 | Synchronous data-register read strobe |
| get_stb | input | 1 | Synchronous group-execute-trigger strobe |
| lbus_stb | input | 1 | Synchronous local-bus transfer strobe |
| arm_start | input | 1 | Arm pulse: load count, go busy |
| abort | input | 1 | Abort pulse: go idle |
| sample_stb | output | 1 | One-cycle sample strobe |
| busy | output | 1 | Controller is armed and accepting triggers |

## Verification
The assertions assume that `abort`, `arm_start` and the bus strobes are synchronous single-cycle pulses. They also assume that asynchronous lines stay at each level for at least three clocks, so that every edge survives the synchronizer. The stimulus drives all inputs on the falling edge. It holds each line high and then low for several cycles, and it changes control words only while no trigger is in flight. This keeps every edge whole and every strobe one cycle long.

// File: rtl/smp_trig_pkg.sv
package smp_trig_pkg;
  localparam int unsigned NUM_LINES = 6;
  localparam int unsigned LN_REF  = 0;
  localparam int unsigned LN_ECL0 = 1;
  localparam int unsigned LN_EXT1 = 2;
  localparam int unsigned LN_ECL1 = 3;
  localparam int unsigned LN_EXT2 = 4;
  localparam int unsigned LN_TTL  = 5;

  typedef enum logic [2:0] {
    SRC_REF  = 3'd0,
    SRC_ECL0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_INT  = 3'd3,
    SRC_DIV  = 3'd4,
    SRC_ECL1 = 3'd5,
    SRC_EXT2 = 3'd6,
    SRC_NONE = 3'd7
  } src_e;

  typedef enum logic [1:0] {
    INT_BUSRD = 2'd0,
    INT_GET   = 2'd1,
    INT_TTL   = 2'd2,
    INT_LBUS  = 2'd3
  } int_src_e;

  typedef struct packed {
    logic     hold;
    logic     inf;
    logic     once;
    src_e     src;
    int_src_e sub;
  } ctrl_t;
endpackage

// File: rtl/smp_edge_sync.sv
module smp_edge_sync #(
  parameter int unsigned N      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] rise_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0][N-1:0] pipe_q, pipe_d;

  always_comb begin
    pipe_d[0] = raw_i;
    for (int s = 1; s < DEPTH; s++) pipe_d[s] = pipe_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R5: a synchronized edge lasts a single cycle
    assert_single_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/smp_ref_div.sv
module smp_ref_div #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [W-1:0] n_i,
  input  logic         tick_i,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q, cnt_d, n_eff;
  logic         pulse_q, pulse_d, wrap;

  always_comb begin
    n_eff   = (n_i == '0) ? W'(1) : n_i;
    wrap    = (cnt_q >= n_eff - W'(1));
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d   = wrap ? '0 : cnt_q + W'(1);
      pulse_d = wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  // R11: a divided event only follows a reference tick
  assert_div_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(tick_i));
  // R11: a restart produces no event
  assert_div_clr_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !pulse_q);
endmodule

// File: rtl/smp_trig_fsm.sv
module smp_trig_fsm #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          inf_i,
  input  logic          once_i,
  input  logic          trig_i,
  input  logic          arm_i,
  input  logic          abort_i,
  input  logic [CW-1:0] load_i,
  output logic          sample_o,
  output logic          busy_o
);
  logic          busy_q, busy_d, sample_q, sample_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          accept, last;

  always_comb begin
    accept   = busy_q & trig_i & ~hold_i & ~abort_i;
    last     = accept & ~inf_i & (once_i | (cnt_q <= CW'(1)));
    sample_d = accept;
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    if (abort_i)      busy_d = 1'b0;
    else if (arm_i)   busy_d = 1'b1;
    else if (last)    busy_d = 1'b0;
    if (arm_i && !abort_i)          cnt_d = load_i;
    else if (accept && cnt_q != '0) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      sample_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      busy_q   <= busy_d;
      sample_q <= sample_d;
      cnt_q    <= cnt_d;
    end
  end

  assign sample_o = sample_q;
  assign busy_o   = busy_q;

  assert_hold_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !sample_q);
  assert_abort_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_q && !sample_q));
  assert_once_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_q && $past(once_i && !inf_i && !arm_i && !abort_i)) |-> !busy_q);
  assert_inf_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && inf_i && !abort_i) |=> busy_q);
  assert_idle_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sample_q |-> $past(busy_q));
endmodule

// File: rtl/smp_trig_ctl.sv
module smp_trig_ctl
  import smp_trig_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [7:0]       ctrl_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic [5:0]       trig_lines,
  input  logic             bus_rd_stb,
  input  logic             get_stb,
  input  logic             lbus_stb,
  input  logic             arm_start,
  input  logic             abort,
  output logic             sample_stb,
  output logic             busy
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cnt_reg_q, cnt_reg_d;
  logic [DIV_W-1:0] div_reg_q, div_reg_d;
  logic [NUM_LINES-1:0] rise;
  logic             div_pulse, trig_sel;

  always_comb begin
    ctrl_d    = ctrl_we ? ctrl_t'(ctrl_wdata) : ctrl_q;
    cnt_reg_d = cnt_we  ? cnt_wdata : cnt_reg_q;
    div_reg_d = div_we  ? div_wdata : div_reg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      cnt_reg_q <= '0;
      div_reg_q <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      cnt_reg_q <= cnt_reg_d;
      div_reg_q <= div_reg_d;
    end
  end

  smp_edge_sync #(.N(NUM_LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(trig_lines), .rise_o(rise));

  smp_ref_div #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr_i(div_we), .n_i(div_reg_q),
    .tick_i(rise[LN_REF]), .pulse_o(div_pulse));

  always_comb begin
    trig_sel = 1'b0;
    unique case (ctrl_q.src)
      SRC_REF:  trig_sel = rise[LN_REF];
      SRC_ECL0: trig_sel = rise[LN_ECL0];
      SRC_EXT1: trig_sel = rise[LN_EXT1];
      SRC_DIV:  trig_sel = div_pulse;
      SRC_ECL1: trig_sel = rise[LN_ECL1];
      SRC_EXT2: trig_sel = rise[LN_EXT2];
      SRC_NONE: trig_sel = 1'b0;
      SRC_INT: begin
        unique case (ctrl_q.sub)
          INT_BUSRD: trig_sel = bus_rd_stb;
          INT_GET:   trig_sel = get_stb;
          INT_TTL:   trig_sel = rise[LN_TTL];
          INT_LBUS:  trig_sel = lbus_stb;
          default:   trig_sel = 1'b0;
        endcase
      end
      default:  trig_sel = 1'b0;
    endcase
  end

  smp_trig_fsm #(.CW(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .hold_i(ctrl_q.hold), .inf_i(ctrl_q.inf), .once_i(ctrl_q.once),
    .trig_i(trig_sel), .arm_i(arm_start), .abort_i(abort),
    .load_i(cnt_reg_q), .sample_o(sample_stb), .busy_o(busy));

  // R4: the unused source code yields nothing
  assert_none_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.src == SRC_NONE && !ctrl_we) |=> !sample_stb);
endmodule

// File: tb/smp_trig_ctl_tb.sv
module smp_trig_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0, cnt_we = 1'b0, div_we = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic [15:0] cnt_wdata = '0, div_wdata = '0;
  logic [5:0]  trig_lines = '0;
  logic        bus_rd_stb = 1'b0, get_stb = 1'b0, lbus_stb = 1'b0;
  logic        arm_start = 1'b0, abort = 1'b0;
  logic        sample_stb, busy;

  int checks = 0, fails = 0, nsamp = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  smp_trig_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .div_we(div_we), .div_wdata(div_wdata),
    .trig_lines(trig_lines), .bus_rd_stb(bus_rd_stb), .get_stb(get_stb),
    .lbus_stb(lbus_stb), .arm_start(arm_start), .abort(abort),
    .sample_stb(sample_stb), .busy(busy));

  always @(negedge clk) if (sample_stb) nsamp++;

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input bit h, input bit inf, input bit once,
                                    input int src, input int sub);
    return {h, inf, once, 3'(src), 2'(sub)};
  endfunction

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_wdata = v; ctrl_we = 1'b1;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_cnt(input int v);
    @(negedge clk); cnt_wdata = 16'(v); cnt_we = 1'b1;
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic wr_div(input int v);
    @(negedge clk); div_wdata = 16'(v); div_we = 1'b1;
    @(negedge clk); div_we = 1'b0;
  endtask

  task automatic do_arm();
    @(negedge clk); arm_start = 1'b1;
    @(negedge clk); arm_start = 1'b0;
  endtask

  // stimulus index: 0..5 async lines, 6 bus read, 7 group execute, 8 local bus
  task automatic fire(input int s);
    @(negedge clk);
    if (s < 6) begin
      trig_lines[s] = 1'b1;
      repeat (4) @(negedge clk);
      trig_lines[s] = 1'b0;
    end else begin
      if (s == 6) bus_rd_stb = 1'b1;
      if (s == 7) get_stb = 1'b1;
      if (s == 8) lbus_stb = 1'b1;
      @(negedge clk);
      bus_rd_stb = 1'b0; get_stb = 1'b0; lbus_stb = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic fire_n(input int s, input int n);
    for (int i = 0; i < n; i++) fire(s);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base, sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy, 0, "R13 busy after reset");
    check(sample_stb, 0, "R13 strobe after reset");
    base = nsamp; fire(0);
    check(nsamp - base, 0, "R12 idle ref trigger ignored");

    // source sweep
    wr_div(1);
    wr_cnt(1000);
    for (int c = 0; c < 8; c++) begin
      for (int sb = 0; sb < ((c == 3) ? 4 : 1); sb++) begin
        case (c)
          0: sel = 0; 1: sel = 1; 2: sel = 2; 4: sel = 0;
          5: sel = 3; 6: sel = 4; 7: sel = -1;
          default: sel = (sb == 0) ? 6 : (sb == 1) ? 7 : (sb == 2) ? 5 : 8;
        endcase
        wr_ctrl(mk(0, 0, 0, c, sb));
        do_arm();
        for (int s = 0; s < 9; s++) begin
          base = nsamp; fire(s);
          if (c == 7) check(nsamp - base, 0, "R4 code 111 silent");
          else if (c == 3) check(nsamp - base, (s == sel) ? 1 : 0, "R3 internal select");
          else check(nsamp - base, (s == sel) ? 1 : 0, "R2 source select");
        end
      end
    end

    // level held high: one sample only
    wr_ctrl(mk(0, 0, 0, 2, 0)); do_arm();
    base = nsamp;
    @(negedge clk); trig_lines[2] = 1'b1;
    repeat (20) @(negedge clk);
    check(nsamp - base, 1, "R5 held level one sample");
    trig_lines[2] = 1'b0; repeat (6) @(negedge clk);

    // post-arm counts
    for (int k = 0; k < 6; k++) begin
      wr_cnt(k); do_arm();
      base = nsamp; fire_n(2, 8);
      check(nsamp - base, (k == 0) ? 1 : k, "R6 post-arm count");
      check(busy, 0, "R6 idle after count");
    end

    // one-shot
    wr_cnt(5); wr_ctrl(mk(0, 0, 1, 2, 0)); do_arm();
    base = nsamp; fire_n(2, 4);
    check(nsamp - base, 1, "R7 one-shot single sample");
    check(busy, 0, "R7 one-shot idle");

    // infinite overrides one-shot, then cleared with count exhausted
    wr_cnt(2); wr_ctrl(mk(0, 1, 1, 2, 0)); do_arm();
    base = nsamp; fire_n(2, 6);
    check(nsamp - base, 6, "R8 infinite past count");
    check(busy, 1, "R8 infinite stays busy");
    wr_ctrl(mk(0, 0, 0, 2, 0));
    check(busy, 1, "R9 busy after clearing infinite");
    base = nsamp; fire_n(2, 3);
    check(nsamp - base, 1, "R9 one extra sample");
    check(busy, 0, "R9 idle after extra");

    // infinite cleared with count left
    wr_cnt(5); wr_ctrl(mk(0, 1, 0, 2, 0)); do_arm();
    fire_n(2, 2);
    wr_ctrl(mk(0, 0, 0, 2, 0));
    base = nsamp; fire_n(2, 6);
    check(nsamp - base, 3, "R9 remaining count honoured");

    // hold
    wr_cnt(4); wr_ctrl(mk(1, 0, 0, 2, 0)); do_arm();
    base = nsamp; fire_n(2, 3); fire(6);
    check(nsamp - base, 0, "R1 hold blocks");
    check(busy, 1, "R1 hold keeps busy");
    wr_ctrl(mk(0, 0, 0, 2, 0));
    base = nsamp; fire(2);
    check(nsamp - base, 1, "R1 release hold");

    // abort
    wr_cnt(10); do_arm(); fire(2);
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    check(busy, 0, "R10 abort idles");
    base = nsamp; fire(2);
    check(nsamp - base, 0, "R10 no sample after abort");
    @(negedge clk); abort = 1'b1; arm_start = 1'b1;
    @(negedge clk); abort = 1'b0; arm_start = 1'b0;
    check(busy, 0, "R10 abort beats arm");

    // divider sweep
    wr_cnt(1000);
    wr_ctrl(mk(0, 0, 0, 4, 0));
    for (int n = 0; n < 6; n++) begin
      wr_div(n); do_arm();
      base = nsamp; fire_n(0, 12);
      check(nsamp - base, 12 / ((n == 0) ? 1 : n), "R11 divided reference");
    end
    finish_run();
  end
endmodule